// File: doc/BRIEF.md
# Pulse-Width Clock-Data Decoder

This block recovers a bit stream and a steady half-rate clock from a single line. The line rises once at the start of every bit period, and the data sits in where it falls. A short high phase, about a quarter of the period, carries a 0. A long high phase, about three quarters of the period, carries a 1. A local clock samples the line at eight samples per bit period.

After a two-flop synchroniser, the block finds each rising edge and counts samples from it. It takes the data bit at the half-period point, which is 180 degrees after the edge. Each bit is presented with a one-cycle valid strobe, and the bits are packed MSB first into words of a configurable width. A flop that toggles only on detected rising edges gives a half-rate enable with a fixed 50% duty cycle, whatever the data pattern. Nothing downstream is timed from the data-dependent falling edge. A watchdog on the gap between rising edges flags a lost line and discards any partly built word.

Top module: `pwcd_decoder`

## Requirements
- R1: While `rst_n` is low, `bit_valid`, `bit_out`, `word_valid`, `word_out`, `half_clk_en` and `loss_flag` are all 0.
- R2: A rising edge is a line sample of 1 after a sample of 0, both taken through the synchroniser. Suppose the first sample of 1 is captured at clock edge n. If the decoder is locked, or if this edge locks it, then `bit_valid` is 1 for exactly one cycle after edge n+6. This holds provided no further rising edge is captured before edge n+5.
- R3: The bit presented is the line level captured at clock edge n+4, four samples after the edge. A symbol high for 2 of 8 samples (or for 4 or fewer) gives 0. A symbol high for 6 of 8 samples (or for 5 or more) gives 1.
- R4: Each rising edge yields at most one bit, so `bit_valid` is never high on two consecutive cycles. No bit is produced before the first rising edge after reset, or after a loss before the next rising edge.
- R5: `half_clk_en` inverts once for each detected rising edge, taking its new value after edge n+2. It is unchanged in every other cycle, whatever the high time of the symbol.
- R6: Bits are shifted into `word_out` MSB first. When the WORD_BITS-th bit since the last word or loss arrives, `word_out` shows the word and `word_valid` is 1 in the same cycle as that bit's `bit_valid`.
- R7: Up to 12 clocks between detected rising edges is tolerated. At 13 or more, `loss_flag` goes to 1, the partial word is dropped and no bits are produced. The flag returns to 0 one clock after the next detected rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, eight cycles per bit period |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Asynchronous pulse-width coded line |
| bit_out | output | 1 | Most recent decoded bit |
| bit_valid | output | 1 | One-cycle strobe for `bit_out` |
| word_out | output | WORD_BITS | Assembled word, first bit in the MSB |
| word_valid | output | 1 | One-cycle strobe for `word_out` |
| half_clk_en | output | 1 | Half-rate enable, toggles on each detected rising edge |
| loss_flag | output | 1 | Line lost: no rising edge within the allowed gap |

## Verification
The bench drives symbols whose high times sit next to the decision point: 4 samples, which must decode as 0, and 5 samples, which must decode as 1. A sample point off by one cycle would flip these bits. The bench also sends gaps of exactly 12 and 13 clocks between edges. An off-by-one loss watchdog would either flag a legal slow line or miss a dead one. It stops a word half-way with a loss and then sends a fresh word; an assembler that is not cleared would deliver a shifted, mixed word. Runs of very short and very long pulses, and a line stuck high, check that the half-rate enable moves only on rising edges and that a line with no transitions is reported as lost.

// File: rtl/pwcd_pkg.sv
package pwcd_pkg;
  localparam int PWCD_OSR_DEF       = 8;
  localparam int PWCD_LOSS_DEF      = 12;
  localparam int PWCD_WORD_BITS_DEF = 8;

  // Width of a counter that must reach 'limit'.
  function automatic int count_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // Sample offset for a half-period (180 degree) decision point.
  function automatic int half_phase(input int osr);
    return osr / 2;
  endfunction
endpackage

// File: rtl/pwcd_sync.sv
module pwcd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pwcd_edge_timer.sv
module pwcd_edge_timer #(
  parameter int SAMPLE_PHASE = 4,
  parameter int LOSS_LIMIT   = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_sync,
  output logic rise_evt,
  output logic sample_evt,
  output logic loss_evt,
  output logic half_clk_en,
  output logic loss_flag
);
  import pwcd_pkg::*;
  localparam int CW = count_width(LOSS_LIMIT);

  logic          line_prev;
  logic          locked;
  logic [CW-1:0] since_edge;

  // Samples since the last rising edge, saturating at the loss limit.
  function automatic logic [CW-1:0] next_since(input logic [CW-1:0] cur,
                                               input logic rise,
                                               input logic lck);
    if (rise)                          return CW'(1);
    else if (lck && cur < CW'(LOSS_LIMIT)) return cur + CW'(1);
    else                               return cur;
  endfunction

  assign rise_evt   = line_sync & ~line_prev;
  assign sample_evt = locked & ~rise_evt & (since_edge == CW'(SAMPLE_PHASE));
  assign loss_evt   = locked & ~rise_evt & (since_edge == CW'(LOSS_LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_prev   <= 1'b0;
      locked      <= 1'b0;
      since_edge  <= '0;
      half_clk_en <= 1'b0;
      loss_flag   <= 1'b0;
    end else begin
      line_prev  <= line_sync;
      since_edge <= next_since(since_edge, rise_evt, locked);
      if (rise_evt) begin
        locked      <= 1'b1;
        half_clk_en <= ~half_clk_en;
        loss_flag   <= 1'b0;
      end else if (loss_evt) begin
        locked    <= 1'b0;
        loss_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwcd_word_asm.sv
module pwcd_word_asm #(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_evt,
  input  logic                 loss_evt,
  input  logic                 din,
  output logic                 bit_out,
  output logic                 bit_valid,
  output logic [WORD_BITS-1:0] word_out,
  output logic                 word_valid
);
  import pwcd_pkg::*;
  localparam int BW = count_width(WORD_BITS - 1);

  logic [WORD_BITS-1:0] acc;
  logic [BW-1:0]        nbits;
  logic                 word_done;

  function automatic logic [WORD_BITS-1:0] push_msb_first(
      input logic [WORD_BITS-1:0] cur, input logic b);
    return {cur[WORD_BITS-2:0], b};
  endfunction

  assign word_done = sample_evt & (nbits == BW'(WORD_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc        <= '0;
      nbits      <= '0;
      bit_out    <= 1'b0;
      bit_valid  <= 1'b0;
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      bit_valid  <= sample_evt;
      word_valid <= word_done;
      if (sample_evt) bit_out <= din;
      if (loss_evt) begin
        acc   <= '0;
        nbits <= '0;
      end else if (word_done) begin
        word_out <= push_msb_first(acc, din);
        acc      <= '0;
        nbits    <= '0;
      end else if (sample_evt) begin
        acc   <= push_msb_first(acc, din);
        nbits <= nbits + BW'(1);
      end
    end
  end
endmodule

// File: rtl/pwcd_decoder.sv
module pwcd_decoder #(
  parameter int OSR        = pwcd_pkg::PWCD_OSR_DEF,
  parameter int LOSS_LIMIT = pwcd_pkg::PWCD_LOSS_DEF,
  parameter int WORD_BITS  = pwcd_pkg::PWCD_WORD_BITS_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_in,
  output logic                 bit_out,
  output logic                 bit_valid,
  output logic [WORD_BITS-1:0] word_out,
  output logic                 word_valid,
  output logic                 half_clk_en,
  output logic                 loss_flag
);
  localparam int SAMPLE_PHASE = pwcd_pkg::half_phase(OSR);

  // Named internal events, visible to the bound checker.
  logic line_sync;
  logic rise_evt;
  logic sample_evt;
  logic loss_evt;

  pwcd_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(line_in), .dout(line_sync)
  );

  pwcd_edge_timer #(.SAMPLE_PHASE(SAMPLE_PHASE), .LOSS_LIMIT(LOSS_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync),
    .rise_evt(rise_evt), .sample_evt(sample_evt), .loss_evt(loss_evt),
    .half_clk_en(half_clk_en), .loss_flag(loss_flag)
  );

  pwcd_word_asm #(.WORD_BITS(WORD_BITS)) u_asm (
    .clk(clk), .rst_n(rst_n), .sample_evt(sample_evt), .loss_evt(loss_evt),
    .din(line_sync), .bit_out(bit_out), .bit_valid(bit_valid),
    .word_out(word_out), .word_valid(word_valid)
  );
endmodule

// File: rtl/pwcd_checker.sv
module pwcd_checker (
  input logic clk,
  input logic rst_n,
  input logic line_sync,
  input logic rise_evt,
  input logic sample_evt,
  input logic loss_evt,
  input logic bit_out,
  input logic bit_valid,
  input logic word_valid,
  input logic half_clk_en,
  input logic loss_flag
);
  a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  a_r2_valid_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> bit_valid);

  a_r3_bit_is_line_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> (bit_out == $past(line_sync)));

  a_r6_word_with_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> bit_valid);

  a_r5_toggle_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> (half_clk_en != $past(half_clk_en)));

  a_r5_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_evt |=> $stable(half_clk_en));

  a_r7_flag_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    loss_evt |=> loss_flag);

  a_r7_no_bits_while_lost: assert property (@(posedge clk) disable iff (!rst_n)
    loss_flag |-> !bit_valid);
endmodule

bind pwcd_decoder pwcd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .rise_evt(rise_evt),
  .sample_evt(sample_evt), .loss_evt(loss_evt), .bit_out(bit_out),
  .bit_valid(bit_valid), .word_valid(word_valid),
  .half_clk_en(half_clk_en), .loss_flag(loss_flag)
);

// File: tb/sim_pwcd_decoder.sv
`timescale 1ns/1ps
module sim_pwcd_decoder;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         line = 1'b0;
  logic         bit_out, bit_valid, word_valid, half_clk_en, loss_flag;
  logic [W-1:0] word_out;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  pwcd_decoder #(.WORD_BITS(W)) u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line),
    .bit_out(bit_out), .bit_valid(bit_valid), .word_out(word_out),
    .word_valid(word_valid), .half_clk_en(half_clk_en), .loss_flag(loss_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Reference model, driven by the samples the line shows at each rising clock edge.
  bit   hist[$];
  int   gap = 0;          // samples since the last accepted edge
  bit   armed = 0;
  bit   e_bv = 0, e_bit = 0, e_wv = 0, e_half = 0, e_loss = 0;
  int   e_word = 0;
  int   acc = 0, nacc = 0;
  int   words[$];
  bit   last_bit = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      bit now_s, before_s, edge_seen, take, lose;
      hist.push_back(line);
      if (hist.size() > 4) void'(hist.pop_front());
      // Value two captures back and three captures back.
      now_s    = (hist.size() >= 3) ? hist[hist.size()-3] : 1'b0;
      before_s = (hist.size() >= 4) ? hist[hist.size()-4] : 1'b0;
      edge_seen = now_s && !before_s;
      take = armed && !edge_seen && gap == 4;
      lose = armed && !edge_seen && gap == 12;
      e_bv = take;
      e_wv = 0;
      if (take) begin
        e_bit = now_s;
        acc = acc * 2 + now_s;
        nacc++;
        if (nacc == W) begin
          e_wv = 1; e_word = acc; acc = 0; nacc = 0;
        end
      end
      if (lose) begin acc = 0; nacc = 0; end
      if (edge_seen) begin
        e_half = !e_half; e_loss = 0; armed = 1; gap = 1;
      end else begin
        if (lose) begin e_loss = 1; armed = 0; end
        else if (armed && gap < 12) gap++;
      end
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(bit_valid == e_bv, "R2/R4 bit_valid", bit_valid, e_bv);
      if (e_bv) check(bit_out == e_bit, "R3 bit_out", bit_out, e_bit);
      check(word_valid == e_wv, "R6 word_valid", word_valid, e_wv);
      if (e_wv) check(int'(word_out) == e_word, "R6 word_out", word_out, e_word);
      check(half_clk_en == e_half, "R5 half_clk_en", half_clk_en, e_half);
      check(loss_flag == e_loss, "R7 loss_flag", loss_flag, e_loss);
      if (word_valid) words.push_back(int'(word_out));
      if (bit_valid) last_bit = bit_out;
    end
  end

  task automatic shape(input int high, input int period);
    for (int i = 0; i < period; i++) begin
      @(negedge clk);
      line = (i < high);
    end
  endtask

  task automatic sym(input bit b);
    shape(b ? 6 : 2, 8);
  endtask

  task automatic send_word(input int val);
    for (int i = W - 1; i >= 0; i--) sym(val[i]);
  endtask

  task automatic hold(input bit lvl, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line = lvl;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check({bit_valid, bit_out, word_valid, half_clk_en, loss_flag} == 5'b0 && word_out == '0,
          "R1 reset outputs", {bit_valid, word_valid, half_clk_en, loss_flag}, 0);
    rst_n = 1'b1;
    hold(0, 3);

    // R6: MSB-first word
    words.delete();
    send_word(8'hB2);
    sym(0);
    hold(0, 4);
    check(words.size() == 1 && words[0] == 8'hB2, "R6 first word B2",
          words.size() ? words[0] : -1, 8'hB2);

    // R7: gap longer than the limit raises loss and drops the partial word
    hold(0, 20);
    check(loss_flag == 1, "R7 loss after idle", loss_flag, 1);
    send_word(8'h5C);
    hold(0, 2);
    check(words.size() == 2 && words[1] == 8'h5C, "R7/R6 word after loss",
          words.size() > 1 ? words[1] : -1, 8'h5C);
    check(loss_flag == 0, "R7 flag cleared", loss_flag, 0);

    // R3: decision boundary, 4 high -> 0, 5 high -> 1
    shape(4, 8); hold(0, 0); shape(0, 0);
    shape(5, 8);
    check(last_bit == 0, "R3 four-high decodes 0", last_bit, 0);
    shape(2, 8);
    check(last_bit == 1, "R3 five-high decodes 1", last_bit, 1);

    // R7: 12-clock period tolerated, 13 not
    for (int i = 0; i < 4; i++) shape(6, 12);
    check(loss_flag == 0, "R7 gap 12 tolerated", loss_flag, 0);
    for (int i = 0; i < 2; i++) shape(6, 13);
    hold(0, 3);
    check(loss_flag == 1, "R7 gap 13 flagged", loss_flag, 1);

    // R5/R7: stuck high line has no edges
    sym(1);
    hold(1, 25);
    check(loss_flag == 1, "R7 stuck high lost", loss_flag, 1);
    hold(0, 3);

    // Random shapes and periods, all compared against the model
    for (int i = 0; i < 300; i++) begin
      int p = 3 + int'($urandom_range(0, 11));
      int h = 1 + int'($urandom_range(0, p - 2));
      if (i % 3 != 0) shape($urandom_range(0, 1) ? 6 : 2, 8);
      else shape(h, p);
    end
    hold(0, 20);
    finish_run();
  end
endmodule